// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is a 32-pin general-purpose I/O port that sits on a plain memory-mapped word bus. Software sets, for each pin, an output value and whether the pin drives (output) or listens (input), and can read back the synchronized level of every pad. Pad drivers are outside the block: it only presents the output value and an output-enable for each pin.

Any pin can also act as an interrupt source. A 2-bit trigger code per pin selects low level, high level, rising edge or falling edge. Detected events latch into a sticky status register. Software clears status bits by writing ones to them. A mask register gates the status bits onto two registered interrupt lines, one serving pins 0–15 and one serving pins 16–31. Bus reads return data one cycle after the address is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: Reset clears the output-value, direction, mask and both trigger-config registers, so they read 0. During and right after reset, pad_out, pad_oe, irq_lo and irq_hi are 0.
- R2: Word registers sit at these byte offsets: output value 0x00, direction 0x04, pad level 0x08 (read-only), trigger config for pins 0–15 at 0x0C, trigger config for pins 16–31 at 0x10, mask 0x14, status 0x18. bus_rdata shows the register selected by bus_addr at the previous rising edge. Any other offset reads 0.
- R3: pad_out equals the output-value register and pad_oe equals the direction register (1 = drive).
- R4: The pad-level register returns pad_in after a two-flop synchronizer. Writes to offset 0x08 change no register.
- R5: The trigger field for pin n occupies bits [2(n mod 16)+1 : 2(n mod 16)] of the config register for its half. The codes are 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R6: A level trigger sets the pin's status bit in every cycle the synchronized level matches. A cleared bit therefore sets again while the level holds. With the reset default code 0 and pads low, every status bit reads 1.
- R7: An edge trigger sets the status bit once per transition in the chosen direction only. The transition is taken between consecutive synchronized samples.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If a trigger and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R10: irq_lo is the registered OR of status AND mask over pins 0–15, and irq_hi is the same over pins 16–31. A mask of 0 holds both lines low.
- R11: A pad change present before rising edge k sets its status bit at edge k+2 and raises the interrupt line at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for bus_addr / bus_wdata |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels (asynchronous) |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The assertions assume that reset is held for at least one edge and that bus_wr is a clean single-cycle strobe sampled on the rising edge. They also assume that pad_in is stable around that edge so the synchronizer stages compare cleanly. The bench changes pad_in and all bus inputs only on falling edges and releases bus_wr after one cycle. The edge-trigger assertion holds only while the trigger config is unchanged, so it allows for cycles in which the bench rewrites config.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int OFS_OUT     = 'h00;
  localparam int OFS_DIR     = 'h04;
  localparam int OFS_PAD     = 'h08;
  localparam int OFS_TRIG_LO = 'h0C;
  localparam int OFS_TRIG_HI = 'h10;
  localparam int OFS_MASK    = 'h14;
  localparam int OFS_STAT    = 'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

  // R4: each stage carries the previous cycle's value of the one before
  a_r4_stage1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stage1_q == $past(async_i)));
  a_r4_stage2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stage2_q == $past(stage1_q)));
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   lvl_i,
  input  logic [2*N-1:0] cfg_i,
  output logic [N-1:0]   hit_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] is_edge;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    trig_e code;
    assign code       = trig_e'(cfg_i[2*i +: 2]);
    assign is_edge[i] = cfg_i[2*i+1];
    always_comb begin
      unique case (code)
        TRIG_LOW:  hit_o[i] = ~lvl_i[i];
        TRIG_HIGH: hit_o[i] =  lvl_i[i];
        TRIG_RISE: hit_o[i] =  lvl_i[i] & ~prev_q[i];
        TRIG_FALL: hit_o[i] = ~lvl_i[i] &  prev_q[i];
        default:   hit_o[i] = 1'b0;
      endcase
    end
  end

  // R7: an edge-configured pin cannot fire on two consecutive cycles
  a_r7_edge_single: assert property (@(posedge clk) disable iff (rst)
    (|(hit_o & is_edge)) |=>
      (!$stable(cfg_i) || ((hit_o & $past(hit_o & is_edge)) == '0)));
endmodule

// File: rtl/gpio_stat_irq.sv
module gpio_stat_irq #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] stat_o,
  output logic         irq_lo_o,
  output logic         irq_hi_o
);
  localparam int HALF = N / 2;

  logic [N-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      irq_lo_o <= 1'b0;
      irq_hi_o <= 1'b0;
    end else begin
      stat_q   <= (stat_q & ~clr_i) | hit_i;
      irq_lo_o <= |(stat_q[HALF-1:0] & mask_i[HALF-1:0]);
      irq_hi_o <= |(stat_q[N-1:HALF] & mask_i[N-1:HALF]);
    end
  end

  assign stat_o = stat_q;

  // R8: a clear with no competing trigger empties the bit
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~hit_i)) |=> ((stat_q & $past(clr_i & ~hit_i)) == '0));
  // R9: a trigger always leaves its bit set, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|hit_i) |=> ((stat_q & $past(hit_i)) == $past(hit_i)));
  // R10: a zero mask keeps both lines low
  a_r10_masked: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> (!irq_lo_o && !irq_hi_o));
  // R10: upper pins never reach the lower line
  a_r10_split: assert property (@(posedge clk) disable iff (rst)
    ((stat_q[HALF-1:0] & mask_i[HALF-1:0]) == '0) |=> !irq_lo_o);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int N = DATA_W;

  logic [N-1:0] out_q, dir_q, mask_q, trig_lo_q, trig_hi_q;
  logic [N-1:0] lvl_sync, hit, stat, clr;
  logic [N-1:0] rd_mux;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= '0;
      dir_q     <= '0;
      mask_q    <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
    end else if (bus_wr) begin
      if (sel(bus_addr, OFS_OUT))     out_q     <= bus_wdata;
      if (sel(bus_addr, OFS_DIR))     dir_q     <= bus_wdata;
      if (sel(bus_addr, OFS_MASK))    mask_q    <= bus_wdata;
      if (sel(bus_addr, OFS_TRIG_LO)) trig_lo_q <= bus_wdata;
      if (sel(bus_addr, OFS_TRIG_HI)) trig_hi_q <= bus_wdata;
    end
  end

  assign clr = (bus_wr && sel(bus_addr, OFS_STAT)) ? bus_wdata : '0;

  always_comb begin
    rd_mux = '0;
    if (sel(bus_addr, OFS_OUT))     rd_mux = out_q;
    if (sel(bus_addr, OFS_DIR))     rd_mux = dir_q;
    if (sel(bus_addr, OFS_PAD))     rd_mux = lvl_sync;
    if (sel(bus_addr, OFS_TRIG_LO)) rd_mux = trig_lo_q;
    if (sel(bus_addr, OFS_TRIG_HI)) rd_mux = trig_hi_q;
    if (sel(bus_addr, OFS_MASK))    rd_mux = mask_q;
    if (sel(bus_addr, OFS_STAT))    rd_mux = stat;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  gpio_sync #(.W(N)) u_sync (
    .clk(clk), .rst(rst), .async_i(pad_in), .sync_o(lvl_sync)
  );

  gpio_trig_detect #(.N(N)) u_detect (
    .clk(clk), .rst(rst), .lvl_i(lvl_sync),
    .cfg_i({trig_hi_q, trig_lo_q}), .hit_o(hit)
  );

  gpio_stat_irq #(.N(N)) u_stat (
    .clk(clk), .rst(rst), .hit_i(hit), .clr_i(clr), .mask_i(mask_q),
    .stat_o(stat), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  // R1: the cycle after reset, the pins drive nothing
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0 && !irq_lo && !irq_hi));
  // R4: a write to the pad-level offset leaves the drive registers alone
  a_r4_pad_ro: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel(bus_addr, OFS_PAD)) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // {pin, trigger code, level before, level after, expected status bit}
  localparam logic [9:0] VEC [10] = '{
    {5'd3,  2'd1, 1'b0, 1'b1, 1'b1},
    {5'd3,  2'd1, 1'b0, 1'b0, 1'b0},
    {5'd20, 2'd0, 1'b1, 1'b0, 1'b1},
    {5'd20, 2'd0, 1'b1, 1'b1, 1'b0},
    {5'd7,  2'd2, 1'b0, 1'b1, 1'b1},
    {5'd7,  2'd2, 1'b1, 1'b0, 1'b0},
    {5'd31, 2'd3, 1'b1, 1'b0, 1'b1},
    {5'd31, 2'd3, 1'b0, 1'b1, 1'b0},
    {5'd16, 2'd2, 1'b0, 1'b1, 1'b1},
    {5'd15, 2'd3, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs in reset", {pad_out[15:0], pad_oe[15:0]}, 32'h0);
    chk("R1 irq in reset", {30'd0, irq_hi, irq_lo}, 32'h0);
    rst = 1'b0;

    // R1 / R2: register reset values
    rd(8'h00, d); chk("R1 output reg", d, 32'h0);
    rd(8'h04, d); chk("R1 direction reg", d, 32'h0);
    rd(8'h0C, d); chk("R1 trig lo", d, 32'h0);
    rd(8'h10, d); chk("R1 trig hi", d, 32'h0);
    rd(8'h14, d); chk("R1 mask", d, 32'h0);
    // R6: default low-level trigger with pads low sets every bit
    rd(8'h18, d); chk("R6 default low level status", d, 32'hFFFF_FFFF);

    // R3 / R2: drive registers
    wr(8'h00, 32'hA5A5_1234);
    wr(8'h04, 32'hFFFF_0000);
    chk("R3 pad_out", pad_out, 32'hA5A5_1234);
    chk("R3 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(8'h00, d); chk("R2 output readback", d, 32'hA5A5_1234);
    rd(8'h04, d); chk("R2 direction readback", d, 32'hFFFF_0000);

    // R4: synchronized pad level, read-only
    pad_in = 32'h1357_9BDF;
    idle(3);
    rd(8'h08, d); chk("R4 pad level", d, 32'h1357_9BDF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R4 write ignored output", d, 32'hA5A5_1234);
    rd(8'h04, d); chk("R4 write ignored direction", d, 32'hFFFF_0000);
    rd(8'h08, d); chk("R4 pad level after write", d, 32'h1357_9BDF);

    // R2: unmapped offsets
    rd(8'h1C, d); chk("R2 unmapped 0x1C", d, 32'h0);
    rd(8'h40, d); chk("R2 unmapped 0x40", d, 32'h0);

    // R5 / R6 / R7: table of trigger vectors
    for (int i = 0; i < 10; i++) begin
      logic [4:0]  pin;
      logic [1:0]  code;
      logic [31:0] cfg;
      pin  = VEC[i][9:5];
      code = VEC[i][4:3];
      cfg  = 32'(code) << (2 * (pin % 16));
      pad_in = '0;
      pad_in[pin] = VEC[i][2];
      wr(8'h0C, pin < 16 ? cfg : 32'h0);
      wr(8'h10, pin < 16 ? 32'h0 : cfg);
      idle(4);
      wr(8'h18, 32'h1 << pin);
      pad_in[pin] = VEC[i][1];
      idle(5);
      rd(8'h18, d);
      chk($sformatf("R5 R6 R7 vector %0d pin %0d", i, pin), {31'd0, d[pin]}, {31'd0, VEC[i][0]});
    end

    // R6: level trigger re-sets after clear
    pad_in = 32'h0000_1000;
    wr(8'h0C, 32'h0100_0000);          // pin 12 high level
    wr(8'h10, 32'h0);
    idle(3);
    wr(8'h18, 32'h0000_1000);
    idle(3);
    rd(8'h18, d); chk("R6 level re-set", {31'd0, d[12]}, 32'h1);

    // R8: write zero keeps, write one clears (pin 5 rising edge)
    pad_in = '0;
    wr(8'h0C, 32'h0000_0800);          // pin 5 code 2
    idle(4);
    wr(8'h18, 32'h0000_0020);
    pad_in[5] = 1'b1;
    idle(5);
    wr(8'h18, 32'h0);
    rd(8'h18, d); chk("R8 zero write keeps", {31'd0, d[5]}, 32'h1);
    wr(8'h18, 32'h0000_0020);
    idle(2);
    rd(8'h18, d); chk("R8 one write clears", {31'd0, d[5]}, 32'h0);

    // R9: set and clear in the same cycle (pin 9 rising edge)
    pad_in = '0;
    wr(8'h0C, 32'h0008_0000);          // pin 9 code 2
    idle(4);
    wr(8'h18, 32'h0000_0200);
    idle(2);
    pad_in[9] = 1'b1;                  // before edge k
    @(posedge clk); @(posedge clk);    // k, k+1
    wr(8'h18, 32'h0000_0200);          // lands on k+2
    rd(8'h18, d); chk("R9 set wins", {31'd0, d[9]}, 32'h1);

    // R10 / R11: lower line latency (pin 3 high level)
    pad_in = '0;
    wr(8'h0C, 32'h0000_0040);          // pin 3 code 1
    wr(8'h14, 32'h0000_0008);
    idle(3);
    wr(8'h18, 32'h0000_0008);
    idle(2);
    chk("R10 masked quiet", {30'd0, irq_hi, irq_lo}, 32'h0);
    pad_in[3] = 1'b1;                  // before edge k
    @(posedge clk); @(posedge clk); @(posedge clk); // k..k+2
    @(negedge clk);
    chk("R11 irq not yet at k+2", {31'd0, irq_lo}, 32'h0);
    @(negedge clk);
    chk("R11 irq_lo at k+3", {31'd0, irq_lo}, 32'h1);
    chk("R10 irq_hi stays low", {31'd0, irq_hi}, 32'h0);
    wr(8'h14, 32'h0);
    @(negedge clk);
    chk("R10 zero mask drops irq", {30'd0, irq_hi, irq_lo}, 32'h0);

    // R10 / R7: upper line from pin 20 rising edge
    pad_in = '0;
    wr(8'h0C, 32'h0);
    wr(8'h10, 32'h0000_0200);          // pin 20 code 2
    idle(4);
    wr(8'h18, 32'h0010_0000);
    wr(8'h14, 32'h0010_0000);
    idle(2);
    pad_in[20] = 1'b1;
    idle(6);
    chk("R10 irq_hi up", {30'd0, irq_hi, irq_lo}, 32'h2);
    wr(8'h18, 32'h0010_0000);
    idle(3);
    chk("R7 edge does not re-set", {31'd0, irq_hi}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule